// File: doc/BRIEF.md
# Dual-Issue Instruction Pairing Checker

This block sits between an instruction decoder and two execution pipes. Each cycle it looks at two decoded instructions that are adjacent in program order (an older slot and a younger slot). It decides whether both may be issued together, whether only the older one may go, or whether nothing issues. The older instruction is always placed on pipe 0, and a paired younger instruction is placed on pipe 1. With pairing the block allows up to two instructions per cycle.

Pairing needs all of these: both instructions are marked simple, the older one is not a jump, the younger one reads no register that the older one writes, and the two do not write the same register. Register 0 as a destination never creates a conflict, because writes to it are discarded. Only the older slot's destination and the younger slot's sources and destination take part in the check, so the older slot's source operands and the younger slot's jump flag are not inputs.

The decision is held in a three-state register. `ST_IDLE` means nothing issued, `ST_SOLO` means the older instruction issued alone, and `ST_DUAL` means both issued. When the stall input is low the state moves on every cycle. Transition *t_none* goes to `ST_IDLE` when the older slot is invalid. Transition *t_single* goes to `ST_SOLO` when the older slot is valid and pairing is refused. Transition *t_pair* goes to `ST_DUAL` when pairing is allowed. Any state can take any of these transitions. Transition *t_hold* keeps the current state while stall is high.

Top module: `pair_issue_gate`

## Requirements
- R1: After reset `issue_both_o`=0, `issue_older_only_o`=0 and `pipe_used_o`=2'b00.
- R2: If the older slot is invalid, neither issue output is set on the following cycle and `pipe_used_o`=2'b00.
- R3: With a valid older slot and an invalid younger slot, only the older instruction issues: `issue_older_only_o`=1 and `pipe_used_o`=2'b01.
- R4: Two valid, simple, conflict-free instructions whose older one is not a jump issue together: `issue_both_o`=1 and `pipe_used_o`=2'b11. Bit 0 of `pipe_used_o` is pipe 0, which carries the older instruction. Bit 1 is pipe 1, which carries the younger one.
- R5: If either instruction is not simple, only the older one issues.
- R6: If an enabled younger source (index i is bits [i*REG_W +: REG_W] of `young_src_i`, enabled by bit i of `young_src_use_i`) equals the older destination and the older write enable is set, only the older one issues. A source whose use bit is clear creates no conflict.
- R7: If both write enables are set and the destinations are equal, only the older one issues.
- R8: If the older instruction is a jump, only the older one issues.
- R9: A destination of register 0 never produces a read-after-write or write-after-write conflict.
- R10: While `stall_i` is high, all outputs keep their previous values.
- R11: Outputs are registered and reflect the inputs of the previous cycle. `issue_both_o` and `issue_older_only_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stall_i | input | 1 | Hold the previous decision |
| old_valid_i | input | 1 | Older slot holds an instruction |
| old_simple_i | input | 1 | Older instruction is simple |
| old_jump_i | input | 1 | Older instruction is a jump |
| old_wr_en_i | input | 1 | Older instruction writes a register |
| old_dst_i | input | REG_W | Older destination register |
| young_valid_i | input | 1 | Younger slot holds an instruction |
| young_simple_i | input | 1 | Younger instruction is simple |
| young_wr_en_i | input | 1 | Younger instruction writes a register |
| young_dst_i | input | REG_W | Younger destination register |
| young_src_use_i | input | NUM_SRC | Per-source read enables of the younger slot |
| young_src_i | input | NUM_SRC*REG_W | Packed younger source registers |
| issue_both_o | output | 1 | Both instructions issued |
| issue_older_only_o | output | 1 | Only the older instruction issued |
| pipe_used_o | output | 2 | Pipe occupancy: bit 0 pipe 0 (older), bit 1 pipe 1 (younger) |

## Verification
Two cases need care because they can occur in the same cycle. In the first, stall is high while a fully pairable pair sits at the inputs. The bench drives a pairable pair with stall raised right after a solo decision, and passes only if the solo outputs are kept. In the second, a read-after-write conflict and a write-after-write conflict are both present, and both are also aimed at register 0. The first combination must refuse pairing, while the register-0 version must still pair.

// File: rtl/pair_pkg.sv
package pair_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SOLO = 2'd1,
        ST_DUAL = 2'd2
    } issue_state_e;
endpackage

// File: rtl/pair_hazard.sv
module pair_hazard #(
    parameter int REG_W   = 5,
    parameter int NUM_SRC = 2
) (
    input  logic                     old_wr_en,
    input  logic [REG_W-1:0]         old_dst,
    input  logic                     young_wr_en,
    input  logic [REG_W-1:0]         young_dst,
    input  logic [NUM_SRC-1:0]       young_src_use,
    input  logic [NUM_SRC*REG_W-1:0] young_src,
    output logic                     raw,
    output logic                     waw
);
    localparam logic [REG_W-1:0] ZERO_REG = '0;

    logic               old_live;
    logic [NUM_SRC-1:0] src_hit;

    assign old_live = old_wr_en && (old_dst != ZERO_REG);

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        assign src_hit[i] = young_src_use[i] &&
                            (young_src[i*REG_W +: REG_W] == old_dst);
    end

    assign raw = old_live && (|src_hit);
    assign waw = old_live && young_wr_en && (young_dst == old_dst);
endmodule

// File: rtl/pair_rules.sv
module pair_rules (
    input  logic old_valid,
    input  logic old_simple,
    input  logic old_jump,
    input  logic young_valid,
    input  logic young_simple,
    input  logic raw,
    input  logic waw,
    output logic pair_ok,
    output logic older_ok
);
    logic class_ok;
    logic dep_free;

    assign class_ok = old_simple && young_simple && !old_jump;
    assign dep_free = !raw && !waw;
    assign older_ok = old_valid;
    assign pair_ok  = old_valid && young_valid && class_ok && dep_free;
endmodule

// File: rtl/pair_issue_gate.sv
module pair_issue_gate
    import pair_pkg::*;
#(
    parameter int REG_W   = 5,
    parameter int NUM_SRC = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     stall_i,
    input  logic                     old_valid_i,
    input  logic                     old_simple_i,
    input  logic                     old_jump_i,
    input  logic                     old_wr_en_i,
    input  logic [REG_W-1:0]         old_dst_i,
    input  logic                     young_valid_i,
    input  logic                     young_simple_i,
    input  logic                     young_wr_en_i,
    input  logic [REG_W-1:0]         young_dst_i,
    input  logic [NUM_SRC-1:0]       young_src_use_i,
    input  logic [NUM_SRC*REG_W-1:0] young_src_i,
    output logic                     issue_both_o,
    output logic                     issue_older_only_o,
    output logic [1:0]               pipe_used_o
);
    localparam logic [REG_W-1:0] ZERO_REG = '0;

    issue_state_e state_q, state_nx;
    logic raw, waw, pair_ok, older_ok;

    pair_hazard #(.REG_W(REG_W), .NUM_SRC(NUM_SRC)) u_hazard (
        .old_wr_en     (old_wr_en_i),
        .old_dst       (old_dst_i),
        .young_wr_en   (young_wr_en_i),
        .young_dst     (young_dst_i),
        .young_src_use (young_src_use_i),
        .young_src     (young_src_i),
        .raw           (raw),
        .waw           (waw)
    );

    pair_rules u_rules (
        .old_valid    (old_valid_i),
        .old_simple   (old_simple_i),
        .old_jump     (old_jump_i),
        .young_valid  (young_valid_i),
        .young_simple (young_simple_i),
        .raw          (raw),
        .waw          (waw),
        .pair_ok      (pair_ok),
        .older_ok     (older_ok)
    );

    // Register 0 as destination never yields a dependence
    AST_ZERO_DST_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (old_dst_i == ZERO_REG) |-> (!raw && !waw)); // R9

    // Next-state selection: t_hold, t_pair, t_single, t_none
    always_comb begin
        state_nx = state_q;
        if (!stall_i) begin
            if (pair_ok)       state_nx = ST_DUAL;
            else if (older_ok) state_nx = ST_SOLO;
            else               state_nx = ST_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    always_comb begin
        issue_both_o       = 1'b0;
        issue_older_only_o = 1'b0;
        pipe_used_o        = 2'b00;
        unique case (state_q)
            ST_IDLE: ;
            ST_SOLO: begin
                issue_older_only_o = 1'b1;
                pipe_used_o        = 2'b01;
            end
            ST_DUAL: begin
                issue_both_o = 1'b1;
                pipe_used_o  = 2'b11;
            end
            default: ;
        endcase
    end

    AST_ONE_DECISION: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({issue_both_o, issue_older_only_o})); // R11
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        stall_i |=> ($stable(issue_both_o) && $stable(issue_older_only_o)
                     && $stable(pipe_used_o))); // R10
    AST_NO_OLDER_NO_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall_i && !old_valid_i) |=> (pipe_used_o == 2'b00)); // R2
    AST_YOUNG_ABSENT_SOLO: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall_i && old_valid_i && !young_valid_i) |=> issue_older_only_o); // R3
    AST_JUMP_BLOCKS_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall_i && old_jump_i) |=> !issue_both_o); // R8
    AST_PAIR_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall_i && pair_ok) |=> (issue_both_o && pipe_used_o == 2'b11)); // R4
endmodule

// File: tb/tb_pair_issue_gate.sv
`timescale 1ns/1ps
module tb_pair_issue_gate;
    localparam int REG_W   = 5;
    localparam int NUM_SRC = 2;

    typedef struct {
        bit       v, s, j, we;
        bit [4:0] d;
        bit [1:0] u;
        bit [4:0] s0, s1;
    } slot_t;

    typedef struct {
        bit       both, solo;
        bit [1:0] pipe;
        string    req;
    } exp_t;

    logic clk = 0, rst_n = 0, stall = 0;
    logic ov, os, oj, owe, yv, ys, ywe;
    logic [4:0] od, yd;
    logic [1:0] yu;
    logic [9:0] ysrc;
    logic ib, io;
    logic [1:0] pu;

    int n_chk = 0, n_fail = 0;
    exp_t q[$];
    exp_t last;

    always #4 clk = ~clk;

    pair_issue_gate #(.REG_W(REG_W), .NUM_SRC(NUM_SRC)) dut (
        .clk(clk), .rst_n(rst_n), .stall_i(stall),
        .old_valid_i(ov), .old_simple_i(os), .old_jump_i(oj),
        .old_wr_en_i(owe), .old_dst_i(od),
        .young_valid_i(yv), .young_simple_i(ys), .young_wr_en_i(ywe),
        .young_dst_i(yd), .young_src_use_i(yu), .young_src_i(ysrc),
        .issue_both_o(ib), .issue_older_only_o(io), .pipe_used_o(pu));

    function automatic slot_t mk(bit v, bit s, bit j, bit we, bit [4:0] d,
                                 bit [1:0] u, bit [4:0] s0, bit [4:0] s1);
        slot_t r;
        r.v = v; r.s = s; r.j = j; r.we = we; r.d = d; r.u = u; r.s0 = s0; r.s1 = s1;
        return r;
    endfunction

    function automatic exp_t model(slot_t o, slot_t y, string req);
        exp_t e;
        bit live, dep, pair;
        live = o.we && o.d != 0;
        dep  = live && ((y.u[0] && y.s0 == o.d) || (y.u[1] && y.s1 == o.d)
                        || (y.we && y.d == o.d));
        pair = o.v && y.v && o.s && y.s && !o.j && !dep;
        e.both = pair;
        e.solo = o.v && !pair;
        e.pipe = pair ? 2'b11 : (o.v ? 2'b01 : 2'b00);
        e.req  = req;
        return e;
    endfunction

    task automatic apply(bit stl, slot_t o, slot_t y, string req);
        exp_t e;
        @(negedge clk);
        stall = stl;
        ov = o.v; os = o.s; oj = o.j; owe = o.we; od = o.d;
        yv = y.v; ys = y.s; ywe = y.we; yd = y.d; yu = y.u; ysrc = {y.s1, y.s0};
        @(posedge clk);
        #1;
        if (stl) begin e = last; e.req = req; end
        else e = model(o, y, req);
        last = e;
        q.push_back(e);
    endtask

    always @(negedge clk) begin
        if (q.size() != 0) begin
            exp_t e;
            e = q.pop_front();
            n_chk++;
            if (ib !== e.both || io !== e.solo || pu !== e.pipe) begin
                n_fail++;
                $display("FAIL %s: got both=%0b solo=%0b pipe=%b exp both=%0b solo=%0b pipe=%b",
                         e.req, ib, io, pu, e.both, e.solo, e.pipe);
            end
        end
    end

    initial begin
        #1_000_000;
        n_fail++; n_chk++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        slot_t A, B;
        ov = 0; os = 0; oj = 0; owe = 0; od = 0;
        yv = 0; ys = 0; ywe = 0; yd = 0; yu = 0; ysrc = 0;
        last.both = 0; last.solo = 0; last.pipe = 0;
        repeat (3) @(negedge clk);
        n_chk++;
        if (ib !== 0 || io !== 0 || pu !== 2'b00) begin
            n_fail++;
            $display("FAIL R1 reset: got both=%0b solo=%0b pipe=%b exp 0 0 00", ib, io, pu);
        end
        rst_n = 1;

        A = mk(1,1,0,1,5'd3,2'b11,5'd1,5'd2);
        B = mk(1,1,0,1,5'd4,2'b11,5'd6,5'd7);
        apply(0, A, B, "R4 clean pair");
        apply(0, mk(0,1,0,1,5'd3,0,0,0), B, "R2 older invalid");
        apply(0, A, mk(0,1,0,1,5'd4,2'b11,5'd6,5'd7), "R3 younger invalid");
        apply(0, mk(1,0,0,1,5'd3,0,0,0), B, "R5 older not simple");
        apply(0, A, mk(1,0,0,1,5'd4,2'b11,5'd6,5'd7), "R5 younger not simple");
        apply(0, A, mk(1,1,0,1,5'd4,2'b11,5'd3,5'd7), "R6 raw on src0");
        apply(0, A, mk(1,1,0,1,5'd4,2'b11,5'd6,5'd3), "R6 raw on src1");
        apply(0, A, mk(1,1,0,1,5'd4,2'b01,5'd6,5'd3), "R6 unused src1 no conflict");
        apply(0, mk(1,1,0,0,5'd3,0,0,0), mk(1,1,0,1,5'd3,2'b11,5'd3,5'd3), "R6 R7 older no write");
        apply(0, A, mk(1,1,0,1,5'd3,2'b00,5'd6,5'd7), "R7 waw");
        apply(0, A, mk(1,1,0,0,5'd3,2'b00,5'd6,5'd7), "R7 younger no write");
        apply(0, mk(1,1,1,1,5'd3,0,0,0), B, "R8 older jump");
        apply(0, A, B, "R8 younger jump irrelevant pair");
        apply(0, mk(1,1,0,1,5'd0,0,0,0), mk(1,1,0,1,5'd0,2'b11,5'd0,5'd0), "R9 zero dest");
        apply(0, A, mk(1,1,0,1,5'd3,2'b11,5'd3,5'd3), "R6 R7 both conflicts");
        apply(1, A, B, "R10 stall over pairable");
        apply(1, mk(0,0,0,0,0,0,0,0), B, "R10 stall over invalid");
        apply(0, A, B, "R11 release after stall");
        apply(1, mk(0,0,0,0,0,0,0,0), B, "R10 stall holds dual");
        apply(0, mk(0,0,0,0,0,0,0,0), B, "R2 idle again");
        for (int k = 0; k < 40; k++) begin
            slot_t o, y;
            o = mk(1, k%5 != 0, k%7 == 0, k%3 != 0, 5'(k%4), 2'(k%4), 5'(k%5), 5'(k%3));
            y = mk(k%9 != 0, k%6 != 0, 0, k%2 == 0, 5'(k%5), 2'((k+1)%4), 5'(k%4), 5'(k%6));
            apply(k%11 == 10, o, y, "R11 mixed sweep");
        end
        repeat (3) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule